// File: doc/BRIEF.md
# Target Selection Controller for a Parallel SCSI Initiator

This block carries out the initiator side of target selection on a parallel SCSI bus that has no arbitration step. A one-cycle `start` pulse names a 3-bit target. The block first confirms that the bus is idle. It then drives the selection byte on the data lines, raising the data-bus enable and the select line together, and polls for the target's busy response at a fixed interval. It reports the outcome with a one-cycle `done` pulse. `ok` qualifies that pulse.

A sticky `selected` flag remembers a successful selection. While the flag is set, a further request is answered with success and the bus is not touched. The surrounding controller pulses `clear_sel` once the bus has gone free or a transfer has been aborted. All bus lines are modelled as synchronous, active-high signals.

Top module: `tgt_select_ctrl`

## Requirements
- R1: After reset, `data_oe`, `sel_out`, `done`, `ok` and `selected` are 0 and `data_out` is 0x00.
- R2: A `start` seen in the idle state while `selected` is 1 gives `done`=1 and `ok`=1 on the next cycle. `data_oe` and `sel_out` stay 0 throughout.
- R3: `bsy_in` or `sel_in` is sampled once per cycle for up to BUSY_SAMPLES (3) cycles after `start`. If every one of those samples is high, the block reports `done`=1 with `ok`=0, and the bus is never driven. One low sample among them lets selection go ahead on the following cycle.
- R4: When driving, `data_out` carries bit INIT_ID (7) together with bit `target_id` (the ID held at `start`). For example, target 3 gives 0x88, target 7 gives 0x80 and target 0 gives 0x81. The value is held steady while it is driven.
- R5: `data_oe` and `sel_out` rise together and fall together.
- R6: `bsy_in` is polled on the first driving cycle and then every TICK_DIV cycles. At the first poll that finds it high, both drives drop, `selected` becomes 1, and `done`=1 with `ok`=1, all in the same cycle.
- R7: If MAX_POLLS polls all find `bsy_in` low, the drives drop and the block reports `done`=1 with `ok`=0. `selected` stays 0. The drive never lasts more than (MAX_POLLS-1)*TICK_DIV+1 cycles.
- R8: `done` is high for exactly one cycle per accepted request. `ok` is high only while `done` is high.
- R9: `clear_sel` makes `selected` 0 on the next cycle, and this takes priority over a success in the same cycle. A later `start` then drives the bus again.
- R10: A `start` that arrives while a selection is in progress has no effect: no extra `done`, and no change to `data_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse for a selection |
| target_id | input | ID_W | Target number, captured with `start` |
| clear_sel | input | 1 | Clears the selected flag |
| bsy_in | input | 1 | Sampled busy line of the bus |
| sel_in | input | 1 | Sampled select line of the bus |
| data_out | output | 2**ID_W | Selection byte for the data lines |
| data_oe | output | 1 | Data-bus drive enable |
| sel_out | output | 1 | Select line drive |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success qualifier for `done` |
| selected | output | 1 | Sticky selected flag |

## Verification
The bench builds the block with TICK_DIV=4 and MAX_POLLS=6. With those values the whole poll window takes only 21 cycles, so the last poll that succeeds and the first response that arrives too late can each be hit exactly. Responses that fall between poll instants check that polls land every TICK_DIV cycles. Busy patterns of one, two and three samples probe the consecutive-sample rule.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WAIT  = 2'd2
    } tsel_state_e;
endpackage

// File: rtl/tsel_tick.sv
module tsel_tick #(
    parameter int DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Fires on the first running cycle, then every DIV cycles.
    assign tick = run && (cnt_q == '0);

    always_comb begin
        cnt_d = '0;
        if (run)
            cnt_d = (cnt_q == CNT_W'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tsel_id_encode.sv
module tsel_id_encode #(
    parameter int ID_W    = 3,
    parameter int INIT_ID = 7
) (
    input  logic [ID_W-1:0]      id,
    output logic [(1<<ID_W)-1:0] code
);
    localparam int DW = 1 << ID_W;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign code[i] = (id == ID_W'(i)) || (i == INIT_ID);
    end
endmodule

// File: rtl/tgt_select_ctrl.sv
module tgt_select_ctrl
    import tsel_pkg::*;
#(
    parameter int ID_W         = 3,
    parameter int TICK_DIV     = 10000,
    parameter int MAX_POLLS    = 2500,
    parameter int BUSY_SAMPLES = 3,
    parameter int INIT_ID      = (1 << ID_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ID_W-1:0]      target_id,
    input  logic                 clear_sel,
    input  logic                 bsy_in,
    input  logic                 sel_in,
    output logic [(1<<ID_W)-1:0] data_out,
    output logic                 data_oe,
    output logic                 sel_out,
    output logic                 done,
    output logic                 ok,
    output logic                 selected
);
    localparam int DW     = 1 << ID_W;
    localparam int SMP_W  = $clog2(BUSY_SAMPLES + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        tsel_state_e       state;
        logic [ID_W-1:0]   id;
        logic [SMP_W-1:0]  smp;
        logic [POLL_W-1:0] polls;
        logic [DW-1:0]     data;
        logic              oe;
        logic              sel;
        logic              done;
        logic              ok;
        logic              selected;
    } regs_t;

    regs_t q, d;
    logic  poll_tick;
    logic [DW-1:0] id_code;

    tsel_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.state == ST_WAIT),
        .tick  (poll_tick)
    );

    tsel_id_encode #(.ID_W(ID_W), .INIT_ID(INIT_ID)) u_enc (
        .id   (q.id),
        .code (id_code)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ok   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (q.selected) begin
                        d.done = 1'b1;
                        d.ok   = 1'b1;
                    end else begin
                        d.state = ST_CHECK;
                        d.id    = target_id;
                        d.smp   = '0;
                    end
                end
            end
            ST_CHECK: begin
                if (bsy_in || sel_in) begin
                    if (q.smp == SMP_W'(BUSY_SAMPLES - 1)) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.smp = q.smp + 1'b1;
                    end
                end else begin
                    d.state = ST_WAIT;
                    d.polls = '0;
                    d.data  = id_code;
                    d.oe    = 1'b1;
                    d.sel   = 1'b1;
                end
            end
            ST_WAIT: begin
                if (poll_tick) begin
                    if (bsy_in || q.polls == POLL_W'(MAX_POLLS - 1)) begin
                        d.state    = ST_IDLE;
                        d.oe       = 1'b0;
                        d.sel      = 1'b0;
                        d.data     = '0;
                        d.done     = 1'b1;
                        d.ok       = bsy_in;
                        d.selected = bsy_in;
                    end else begin
                        d.polls = q.polls + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (clear_sel)
            d.selected = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, id: '0, smp: '0, polls: '0, data: '0,
                   oe: 1'b0, sel: 1'b0, done: 1'b0, ok: 1'b0, selected: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data_out = q.data;
    assign data_oe  = q.oe;
    assign sel_out  = q.sel;
    assign done     = q.done;
    assign ok       = q.ok;
    assign selected = q.selected;
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
    parameter int DW        = 8,
    parameter int TICK_DIV  = 10000,
    parameter int MAX_POLLS = 2500,
    parameter int INIT_ID   = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear_sel,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic          sel_out,
    input logic          done,
    input logic          ok,
    input logic          selected
);
    localparam longint WIN_MAX = longint'(MAX_POLLS - 1) * TICK_DIV;

    longint drive_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       drive_cnt <= 0;
        else if (data_oe) drive_cnt <= drive_cnt + 1;
        else              drive_cnt <= 0;
    end

    a_r2_no_drive_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> !data_oe);
    a_r4_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out[INIT_ID] && $countones(data_out) <= 2));
    a_r4_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));
    a_r5_enables_paired: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe == sel_out);
    a_r6_flag_set_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> (done && ok));
    a_r7_fail_leaves_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> !selected);
    a_r7_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (drive_cnt <= WIN_MAX));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_ok_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> done);
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_sel |=> !selected);
endmodule

bind tgt_select_ctrl tsel_checker #(
    .DW(1 << ID_W), .TICK_DIV(TICK_DIV), .MAX_POLLS(MAX_POLLS), .INIT_ID(INIT_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_sel (clear_sel),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .sel_out   (sel_out),
    .done      (done),
    .ok        (ok),
    .selected  (selected)
);

// File: tb/tb_tgt_select_ctrl.sv
module tb_tgt_select_ctrl;
    localparam int DIV = 4;
    localparam int NP  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] target_id = '0;
    logic       clear_sel = 1'b0;
    logic       bsy_in = 1'b0;
    logic       sel_in = 1'b0;
    logic [7:0] data_out;
    logic       data_oe, sel_out, done, ok, selected;

    always #5 clk = ~clk;

    tgt_select_ctrl #(.TICK_DIV(DIV), .MAX_POLLS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_id(target_id),
        .clear_sel(clear_sel), .bsy_in(bsy_in), .sel_in(sel_in),
        .data_out(data_out), .data_oe(data_oe), .sel_out(sel_out),
        .done(done), .ok(ok), .selected(selected)
    );

    typedef struct {
        logic  ok;
        logic  sel;
        int    lat;
        int    t0;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    ended = 0;

    // target model
    int         resp_cfg = 0;
    logic       bsy_force = 1'b0;
    int         scnt = 0;
    logic       drove = 1'b0;
    logic [7:0] cap = '0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sel_out) begin
            scnt = scnt + 1;
            if (!drove) begin
                drove = 1'b1;
                cap   = data_out;
            end
            bsy_in = bsy_force || (resp_cfg != 0 && scnt >= resp_cfg);
        end else begin
            scnt   = 0;
            bsy_in = bsy_force;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, "ok", int'(ok), int'(e.ok));
                chk(e.req, "selected", int'(selected), int'(e.sel));
                chk(e.req, "latency", cyc - e.t0, e.lat);
            end
        end
    end

    function automatic logic [7:0] code_of(input logic [2:0] id);
        return 8'h80 | (8'd1 << id);
    endfunction

    // busy_n: negedges the chosen line stays high counting the start one; use_bsy picks bsy_in
    task automatic run_sel(input logic [2:0] id, input int resp, input int busy_n,
                           input bit use_bsy, input logic e_ok, input logic e_sel,
                           input int e_lat, input logic e_drive, input string req);
        exp_t e;
        @(negedge clk);
        resp_cfg  = resp;
        drove     = 1'b0;
        target_id = id;
        start     = 1'b1;
        if (busy_n > 0) begin
            if (use_bsy) begin bsy_force = 1'b1; bsy_in = 1'b1; end
            else sel_in = 1'b1;
        end
        e.ok = e_ok; e.sel = e_sel; e.lat = e_lat; e.t0 = cyc; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i < busy_n; i++) @(negedge clk);
        sel_in = 1'b0;
        bsy_force = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        chk(req, "bus driven", int'(drove), int'(e_drive));
        if (e_drive) chk(req, "selection byte", int'(cap), int'(code_of(id)));
        repeat (2) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_sel = 1'b1;
        @(negedge clk);
        clear_sel = 1'b0;
        chk("R9", "selected after clear", int'(selected), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("WATCHDOG", "timeout", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "data_oe", int'(data_oe), 0);
        chk("R1", "sel_out", int'(sel_out), 0);
        chk("R1", "done/ok", int'({done, ok}), 0);
        chk("R1", "selected", int'(selected), 0);
        chk("R1", "data_out", int'(data_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R6: target answers before the first poll
        run_sel(3'd3, 1, 0, 0, 1, 1, 3, 1, "R6");
        // R2: already selected, bus untouched
        run_sel(3'd5, 1, 0, 0, 1, 1, 1, 0, "R2");
        do_clear();
        // R4 R6: answers at the second and third poll
        run_sel(3'd7, 2, 0, 0, 1, 1, 7, 1, "R4");
        do_clear();
        run_sel(3'd0, 6, 0, 0, 1, 1, 11, 1, "R6");
        do_clear();
        // R7: last poll catches it, one cycle later misses it
        run_sel(3'd2, 1 + (NP - 1) * DIV, 0, 0, 1, 1, 3 + (NP - 1) * DIV, 1, "R7");
        do_clear();
        run_sel(3'd2, 2 + (NP - 1) * DIV, 0, 0, 0, 0, 3 + (NP - 1) * DIV, 1, "R7");
        // R3: three busy samples on either line
        run_sel(3'd1, 1, 4, 0, 0, 0, 4, 0, "R3");
        run_sel(3'd1, 1, 4, 1, 0, 0, 4, 0, "R3");
        // R3: one or two busy samples still go ahead
        run_sel(3'd4, 1, 2, 0, 1, 1, 4, 1, "R3");
        do_clear();
        run_sel(3'd4, 1, 3, 1, 1, 1, 5, 1, "R3");
        do_clear();

        // R10: a second start during the poll window is ignored
        begin
            exp_t e;
            @(negedge clk);
            resp_cfg = 10; drove = 1'b0; target_id = 3'd6; start = 1'b1;
            e.ok = 1; e.sel = 1; e.lat = 15; e.t0 = cyc; e.req = "R10";
            sb.push_back(e);
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            target_id = 3'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R10", "byte during wait", int'(data_out), int'(code_of(3'd6)));
            while (sb.size() != 0) @(negedge clk);
            chk("R10", "selection byte", int'(cap), int'(code_of(3'd6)));
            repeat (30) @(negedge clk);
            chk("R10", "idle after", int'(data_oe), 0);
        end
        do_clear();
        finish_run();
    end
endmodule